// File: doc/BRIEF.md
# Ethernet Destination Address Screen

This block sits in a receive path right after frame delineation and decides, for every incoming Ethernet frame, whether the frame is addressed to this station. It watches the received byte stream and uses only the first six bytes of each frame, which form the destination address. Once the sixth byte is in, it issues a single accept or reject pulse. A downstream buffer manager uses that pulse to keep or drop the frame. The block does not touch the payload or the frame check sequence.

Three rules are applied. An individual address must equal the six programmed station bytes exactly. The all-ones address is a broadcast and passes only while broadcast reception is enabled. A group address, meaning one whose first transmitted bit is set, goes through a 64-bin hash. For the hash, the address bits are clocked least-significant-bit first through a CRC-32 register, and the top six bits of that register select one bit of a 64-bit filter table. The table is held in eight byte-wide registers.

Station bytes, filter bytes and the two enables are written or driven at any time. A frame sees only the values that were in place when its first byte arrived.

Top module: `rx_addr_screen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, neither acceptPulse nor rejectPulse is high. All station and filter registers reset to zero.
- R2: Only the first six bytes after a start are examined. Further bytes of the frame and the end strobe that closes a complete frame produce no pulse.
- R3: For a frame whose six address bytes all arrive, exactly one of acceptPulse or rejectPulse goes high, for exactly one cycle. That cycle is the one after the clock edge that took the sixth byte. Bytes with no preceding start (frameStart together with byteValid) produce no pulse, and the two pulses are never high together.
- R4: When bit 0 of the first address byte is 0, the frame is accepted only if address byte i equals station register i (cfgAddr i, for i = 0 to 5) for all six bytes. A mismatch in any byte rejects the frame.
- R5: When all 48 address bits are 1, the frame is accepted if broadcast reception was enabled at its start and rejected otherwise, whatever the filter table and the multicast enable hold.
- R6: When bit 0 of the first address byte is 1 and the address is not all ones, the frame is accepted only if multicast reception was enabled at its start and the selected filter bit is 1. Filter bit n is bit n mod 8 of filter register n div 8, written at cfgAddr 8 + n div 8. With every filter register at 8'hFF and the enable on, every such frame is accepted.
- R7: The hash bin is computed with CRC-32 polynomial 0x04C11DB7 and the register preset to all ones at frame start. The address bits are shifted in as bit 0 to bit 7 of byte 0, then byte 1, and so on to byte 5. At each step the feedback is the top register bit XOR the data bit, and the register shifts left. After the last address bit, register bits 31 down to 26 form the bin number, with bit 31 as its most significant bit. No inversion is applied.
- R8: If frameEnd arrives after one to five address bytes and the sixth byte does not arrive in that cycle, rejectPulse goes high in the next cycle. If a new start arrives while a frame has one to five bytes, rejectPulse goes high in the next cycle and the new frame begins with that byte.
- R9: A write at cfgAddr 0–5 or 8–15 updates a pending copy. A frame uses the copy and the bcastEn/mcastEn levels present at the edge that takes its first byte, so changes made during a frame take effect only from the next start. Writes at any other cfgAddr change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| frameStart | input | 1 | Marks the byte presented with byteValid as the first of a frame |
| byteValid | input | 1 | rxByte holds a received byte this cycle |
| rxByte | input | 8 | Received byte, bit 0 is the first bit on the wire |
| frameEnd | input | 1 | The current frame has ended |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 4 | Register select: 0–5 station bytes, 8–15 filter bytes |
| cfgData | input | 8 | Register write data |
| bcastEn | input | 1 | Broadcast reception enable, sampled at frame start |
| mcastEn | input | 1 | Multicast hash reception enable, sampled at frame start |
| acceptPulse | output | 1 | One-cycle pulse: frame is addressed to this station |
| rejectPulse | output | 1 | One-cycle pulse: frame is dropped |

## Verification
The bench sweeps hundreds of group addresses against a known filter pattern and against a full table. It computes each bin with its own bit-serial CRC, so a design that reverses the bit order within a byte, drops the preset or picks the wrong six register bits lands in the wrong bin and fails. It flips one bit in each of the six station bytes in turn, which catches a comparator that skips a byte or keeps only the last byte's result. It also drives the all-ones address with the broadcast enable off while the full filter table is on, which exposes a design that lets broadcasts fall through to the hash. It changes the enables and a station byte in the middle of a frame, which exposes a design that reads live configuration. It also drives truncated and restarted frames; a design that handles these wrongly either stays silent or gives a late verdict.

// File: rtl/rx_addr_screen_pkg.sv
package rx_addr_screen_pkg;

  localparam int NUM_ADDR_BYTES = 6;
  localparam int NUM_HASH_BYTES = 8;
  localparam int HASH_BITS      = NUM_HASH_BYTES * 8;
  localparam int BIN_W          = $clog2(HASH_BITS);
  localparam int IDX_W          = $clog2(NUM_ADDR_BYTES + 1);
  localparam int CFG_ADDR_W     = 4;
  localparam int HASH_BASE      = 8;
  localparam int CRC_W          = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  // strobes from sequencing control to the address datapath
  typedef struct packed {
    logic             loadCfg;   // copy pending config into the active set
    logic             firstByte; // current byte opens a new address
    logic             takeByte;  // current byte belongs to the address
    logic [IDX_W-1:0] byteIdx;   // position of the current byte
  } dpStrobe_t;

  // eight CRC steps, data bit 0 first
  function automatic logic [CRC_W-1:0] crcStepByte(input logic [CRC_W-1:0] cIn,
                                                   input logic [7:0] dIn);
    logic [CRC_W-1:0] c;
    logic fb;
    c = cIn;
    for (int k = 0; k < 8; k++) begin
      fb = c[CRC_W-1] ^ dIn[k];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

endpackage

// File: rtl/rx_addr_screen_ctrl.sv
module rx_addr_screen_ctrl
  import rx_addr_screen_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  input  logic      byteValid,
  input  logic      frameEnd,
  output dpStrobe_t strobe,
  output logic      decideQ,
  output logic      abortQ
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ADDR_BYTES - 1);
  localparam logic [IDX_W-1:0] DONE_CNT = IDX_W'(NUM_ADDR_BYTES);

  logic [IDX_W-1:0] byteCnt, byteCntNext;
  logic startNow, busy, lastByte, midByte, shortEnd;

  always_comb begin
    startNow = frameStart & byteValid;
    busy     = (byteCnt != '0) && (byteCnt < DONE_CNT);
    lastByte = byteValid & ~startNow & (byteCnt == LAST_IDX);
    midByte  = byteValid & ~startNow & busy & ~lastByte;
    shortEnd = frameEnd & ~startNow & busy & ~lastByte;
  end

  always_comb begin
    strobe.loadCfg   = startNow;
    strobe.firstByte = startNow;
    strobe.takeByte  = startNow | midByte | lastByte;
    strobe.byteIdx   = startNow ? '0 : byteCnt;
  end

  always_comb begin
    byteCntNext = byteCnt;
    if (startNow)      byteCntNext = IDX_W'(1);
    else if (lastByte) byteCntNext = DONE_CNT;
    else if (shortEnd) byteCntNext = '0;
    else if (midByte)  byteCntNext = byteCnt + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      decideQ <= 1'b0;
      abortQ  <= 1'b0;
    end else begin
      byteCnt <= byteCntNext;
      decideQ <= lastByte;
      abortQ  <= shortEnd | (startNow & busy);
    end
  end

endmodule

// File: rtl/rx_addr_screen_dp.sv
module rx_addr_screen_dp
  import rx_addr_screen_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [7:0]            cfgData,
  input  logic                  bcastEn,
  input  logic                  mcastEn,
  input  logic [7:0]            rxByte,
  input  dpStrobe_t             strobe,
  output logic                  pass
);

  logic [NUM_ADDR_BYTES-1:0][7:0] staPend, staAct, staUse;
  logic [NUM_HASH_BYTES-1:0][7:0] hashPend, hashAct;
  logic [HASH_BITS-1:0]           hashFlat;
  logic                           bcAct, mcAct;

  logic [CRC_W-1:0] crcQ;
  logic             ucMatch, allOnes, groupBit;
  logic [7:0]       staByte;
  logic [BIN_W-1:0] bin;
  logic             hashHit;

  // pending configuration, written at any time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      staPend  <= '0;
      hashPend <= '0;
    end else if (cfgWe) begin
      for (int i = 0; i < NUM_ADDR_BYTES; i++)
        if (cfgAddr == CFG_ADDR_W'(i)) staPend[i] <= cfgData;
      for (int j = 0; j < NUM_HASH_BYTES; j++)
        if (cfgAddr == CFG_ADDR_W'(HASH_BASE + j)) hashPend[j] <= cfgData;
    end
  end

  // active configuration, frozen at each frame start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      staAct  <= '0;
      hashAct <= '0;
      bcAct   <= 1'b0;
      mcAct   <= 1'b0;
    end else if (strobe.loadCfg) begin
      staAct  <= staPend;
      hashAct <= hashPend;
      bcAct   <= bcastEn;
      mcAct   <= mcastEn;
    end
  end

  // the first byte compares against the values being loaded in the same edge
  for (genvar g = 0; g < NUM_ADDR_BYTES; g++) begin : g_staSel
    assign staUse[g] = strobe.loadCfg ? staPend[g] : staAct[g];
  end

  always_comb begin
    staByte = '0;
    for (int i = 0; i < NUM_ADDR_BYTES; i++)
      if (strobe.byteIdx == IDX_W'(i)) staByte = staUse[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ     <= '1;
      ucMatch  <= 1'b0;
      allOnes  <= 1'b0;
      groupBit <= 1'b0;
    end else if (strobe.takeByte) begin
      crcQ    <= crcStepByte(strobe.firstByte ? '1 : crcQ, rxByte);
      ucMatch <= (strobe.firstByte | ucMatch) & (rxByte == staByte);
      allOnes <= (strobe.firstByte | allOnes) & (&rxByte);
      if (strobe.firstByte) groupBit <= rxByte[0];
    end
  end

  assign hashFlat = hashAct;
  assign bin      = crcQ[CRC_W-1 -: BIN_W];
  assign hashHit  = hashFlat[bin];

  always_comb begin
    if (allOnes)       pass = bcAct;
    else if (groupBit) pass = mcAct & hashHit;
    else               pass = ucMatch;
  end

endmodule

// File: rtl/rx_addr_screen.sv
module rx_addr_screen
  import rx_addr_screen_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameStart,
  input  logic                  byteValid,
  input  logic [7:0]            rxByte,
  input  logic                  frameEnd,
  input  logic                  cfgWe,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [7:0]            cfgData,
  input  logic                  bcastEn,
  input  logic                  mcastEn,
  output logic                  acceptPulse,
  output logic                  rejectPulse
);

  dpStrobe_t strobe;
  logic decideQ, abortQ, pass;

  rx_addr_screen_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .byteValid (byteValid),
    .frameEnd  (frameEnd),
    .strobe    (strobe),
    .decideQ   (decideQ),
    .abortQ    (abortQ)
  );

  rx_addr_screen_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .cfgData(cfgData),
    .bcastEn(bcastEn),
    .mcastEn(mcastEn),
    .rxByte (rxByte),
    .strobe (strobe),
    .pass   (pass)
  );

  assign acceptPulse = decideQ & pass;
  assign rejectPulse = abortQ | (decideQ & ~pass);

endmodule

// File: rtl/rx_addr_screen_chk.sv
module rx_addr_screen_chk (
  input logic clk,
  input logic rstN,
  input logic frameStart,
  input logic byteValid,
  input logic frameEnd,
  input logic acceptPulse,
  input logic rejectPulse
);

  // address byte count tracked from the ports alone
  logic [2:0] cntC;
  logic       startC;

  assign startC = frameStart & byteValid;

  always_ff @(posedge clk) begin
    if (!rstN)                            cntC <= '0;
    else if (startC)                      cntC <= 3'd1;
    else if (byteValid && cntC == 3'd5)   cntC <= 3'd6;
    else if (frameEnd)                    cntC <= '0;
    else if (byteValid && cntC != 3'd0 && cntC < 3'd5) cntC <= cntC + 3'd1;
  end

  p_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptPulse && rejectPulse));

  p_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    (acceptPulse || rejectPulse) |-> $past(byteValid || frameEnd));

  p_sixth_r3: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !startC && cntC == 3'd5) |=> (acceptPulse ^ rejectPulse));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((cntC == 3'd0 || cntC == 3'd6) && !startC) |=> (!acceptPulse && !rejectPulse));

  p_short_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !startC && cntC != 3'd0 && cntC < 3'd6 && !(byteValid && cntC == 3'd5))
      |=> (rejectPulse && !acceptPulse));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startC && cntC != 3'd0 && cntC < 3'd6) |=> (rejectPulse && !acceptPulse));

endmodule

bind rx_addr_screen rx_addr_screen_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .byteValid  (byteValid),
  .frameEnd   (frameEnd),
  .acceptPulse(acceptPulse),
  .rejectPulse(rejectPulse)
);

// File: tb/rx_addr_screen_test.sv
module rx_addr_screen_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic       clk = 1'b0;
  logic       rstN, frameStart, byteValid, frameEnd, cfgWe, bcastEn, mcastEn;
  logic [7:0] rxByte, cfgData;
  logic [3:0] cfgAddr;
  logic       acceptPulse, rejectPulse;

  int checks = 0;
  int errors = 0;

  logic [47:0] staModel  = '0;
  logic [63:0] hashModel = '0;
  logic [31:0] rs = 32'h1F2E3D4C;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_addr_screen uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
    .rxByte(rxByte), .frameEnd(frameEnd), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .bcastEn(bcastEn), .mcastEn(mcastEn),
    .acceptPulse(acceptPulse), .rejectPulse(rejectPulse)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [5:0] binOf(input logic [47:0] da);
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int n = 0; n < 48; n++) begin
      fb = c[31] ^ da[n];
      c  = (c << 1) ^ (fb ? POLY : 32'h0);
    end
    return c[31:26];
  endfunction

  function automatic bit expOf(input logic [47:0] da, input bit bc, input bit mc);
    if (da == '1) return bc;
    if (da[0])    return mc && hashModel[binOf(da)];
    return da == staModel;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkPulse(input string req, input bit expA, input bit expR);
    chk(acceptPulse == expA, req, "acceptPulse", int'(acceptPulse), int'(expA));
    chk(rejectPulse == expR, req, "rejectPulse", int'(rejectPulse), int'(expR));
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    cfgWe = 1'b1; cfgAddr = 4'(a); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (a < 6) staModel[8*a +: 8] = d;
    else if (a >= 8 && a < 16) hashModel[8*(a-8) +: 8] = d;
  endtask

  // full frame; enables are inverted after the first byte (R9)
  task automatic sendDa(input logic [47:0] da, input bit bc, input bit mc,
                        input bit expAbort, input string req);
    bit e;
    e = expOf(da, bc, mc);
    bcastEn = bc; mcastEn = mc;
    for (int i = 0; i < 6; i++) begin
      frameStart = (i == 0); byteValid = 1'b1; rxByte = da[8*i +: 8];
      @(negedge clk);
      if (i == 0) begin
        bcastEn = !bc; mcastEn = !mc;
        checkPulse("R8", 1'b0, expAbort);
      end else if (i < 5) checkPulse("R3", 1'b0, 1'b0);
      else checkPulse(req, e, !e);
    end
    frameStart = 1'b0;
    for (int i = 0; i < 2; i++) begin
      rxByte = da[7:0];
      @(negedge clk);
      checkPulse("R2", 1'b0, 1'b0);
    end
    byteValid = 1'b0; frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    checkPulse("R2", 1'b0, 1'b0);
  endtask

  task automatic partial(input logic [47:0] da, input int k);
    for (int i = 0; i < k; i++) begin
      frameStart = (i == 0); byteValid = 1'b1; rxByte = da[8*i +: 8];
      @(negedge clk);
      checkPulse("R3", 1'b0, 1'b0);
    end
    frameStart = 1'b0; byteValid = 1'b0;
  endtask

  function automatic logic [47:0] randAddr(input bit grp);
    logic [47:0] a;
    rs = nextRand(rs);
    a[31:0] = rs;
    rs = nextRand(rs);
    a[47:32] = rs[15:0];
    a[0] = grp;
    if (a == '1) a[1] = 1'b0;
    return a;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] sta, da;
    rstN = 1'b0; frameStart = 1'b0; byteValid = 1'b0; frameEnd = 1'b0;
    cfgWe = 1'b0; cfgAddr = '0; cfgData = '0; bcastEn = 1'b0; mcastEn = 1'b0;
    rxByte = '0;
    repeat (3) @(negedge clk);
    checkPulse("R1", 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkPulse("R1", 1'b0, 1'b0);
    // R1: station registers reset to zero
    sendDa(48'h0, 1'b1, 1'b1, 1'b0, "R1");

    // R3: bytes with no start give no verdict
    for (int i = 0; i < 8; i++) begin
      byteValid = 1'b1; rxByte = 8'(i * 29);
      @(negedge clk);
      checkPulse("R3", 1'b0, 1'b0);
    end
    byteValid = 1'b0;

    sta = 48'h715E4D331C02;
    for (int i = 0; i < 6; i++) wr(i, sta[8*i +: 8]);

    // R4 unicast exact match and single-byte mismatches
    sendDa(sta, 1'b0, 1'b0, 1'b0, "R4");
    for (int p = 0; p < 6; p++) sendDa(sta ^ (48'h2 << (8*p)), 1'b1, 1'b1, 1'b0, "R4");
    for (int n = 0; n < 30; n++) sendDa(randAddr(1'b0), 1'b1, 1'b1, 1'b0, "R4");

    // R5 broadcast
    sendDa('1, 1'b1, 1'b0, 1'b0, "R5");
    sendDa('1, 1'b0, 1'b1, 1'b0, "R5");
    for (int j = 0; j < 8; j++) wr(8 + j, 8'hFF);
    sendDa('1, 1'b0, 1'b1, 1'b0, "R5");

    // R6 full table and multicast enable
    for (int n = 0; n < 20; n++) sendDa(randAddr(1'b1), 1'b0, 1'b1, 1'b0, "R6");
    for (int n = 0; n < 10; n++) sendDa(randAddr(1'b1), 1'b1, 1'b0, 1'b0, "R6");

    // R7 bin selection sweep over a mixed table
    for (int j = 0; j < 8; j++) wr(8 + j, 8'h5A ^ 8'(j * 37));
    for (int n = 0; n < 256; n++) sendDa(randAddr(1'b1), 1'b0, 1'b1, 1'b0, "R7");

    // R6 single bin set, then cleared
    for (int n = 0; n < 8; n++) begin
      logic [5:0] b;
      da = randAddr(1'b1);
      b = binOf(da);
      for (int j = 0; j < 8; j++) wr(8 + j, (int'(b[5:3]) == j) ? (8'h1 << b[2:0]) : 8'h00);
      sendDa(da, 1'b0, 1'b1, 1'b0, "R6");
      wr(8 + int'(b[5:3]), 8'h00);
      sendDa(da, 1'b0, 1'b1, 1'b0, "R6");
    end

    // R9 unused register addresses change nothing
    wr(6, 8'h00); wr(7, 8'hFF);
    sendDa(sta, 1'b0, 1'b0, 1'b0, "R9");

    // R9 write during a frame applies from the next start
    partial(sta, 3);
    wr(5, 8'hEE);
    byteValid = 1'b1;
    for (int i = 3; i < 6; i++) begin
      rxByte = sta[8*i +: 8];
      @(negedge clk);
      if (i < 5) checkPulse("R3", 1'b0, 1'b0);
      else checkPulse("R9", 1'b1, 1'b0);
    end
    byteValid = 1'b0;
    @(negedge clk);
    sendDa(sta, 1'b0, 1'b0, 1'b0, "R9");
    wr(5, sta[47:40]);
    sendDa(sta, 1'b0, 1'b0, 1'b0, "R9");

    // R8 short frames
    for (int k = 1; k < 6; k++) begin
      partial(sta, k);
      frameEnd = 1'b1;
      @(negedge clk);
      frameEnd = 1'b0;
      checkPulse("R8", 1'b0, 1'b1);
      @(negedge clk);
      checkPulse("R8", 1'b0, 1'b0);
    end

    // R8 restart mid-address, new frame still judged
    partial(sta, 3);
    sendDa(sta, 1'b0, 1'b0, 1'b1, "R8");
    partial(sta, 5);
    sendDa('1, 1'b1, 1'b0, 1'b1, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule